// File: doc/BRIEF.md
# Half-Band Two-Channel Wavelet Split and Merge

This block splits a stream of signed samples into two half-rate sub-bands with a pair of seven-tap half-band filters, one lowpass and one highpass. It then merges the two sub-bands back into a full-rate stream. The merge side has no filter design of its own. Each sub-band is zero-stuffed back to the full rate and passed through one of the same two filters, with the filters swapped between channels. The difference of the two filter sums is then multiplied by +1 on even output samples and by -1 on odd ones. Swapping the filters and applying this alternating sign cancels the aliasing that decimation brings in. The merged stream is the input delayed by three samples and shaped by a fixed even-tap kernel. That kernel has unity gain at DC and at the Nyquist rate.

All arithmetic uses shifts and adds only. A multiply by nine is eight-times-plus-one, and each scale factor is an arithmetic right shift taken after the sum. The input takes at most one sample per cycle, marked by a valid strobe, and idle cycles are allowed anywhere. Sample indices count accepted samples from 0 after reset. Every delay line clears on reset, so each stream starts from zero history.

Two small state machines set the sequencing. The split side moves from `PH_EVEN` to `PH_ODD` on an accepted sample and back again on the next one. The sample accepted in `PH_EVEN` completes a sub-band pair. The merge side waits in `SY_WAIT`. A sub-band strobe moves it to `SY_ZERO`, and that cycle pushes the pair into the merge filters. `SY_ZERO` then always returns to `SY_WAIT`, and that cycle pushes the stuffed zeros.

Top module: `hbw_bank`

## Requirements
- R1: While reset is held and in the cycle after it is released, `band_valid` and `out_valid` are low and `lo_data`, `hi_data` and `out_data` are zero.
- R2: For each even sample index n, `lo_data` equals floor((-x[n] + 9x[n-2] + 16x[n-3] + 9x[n-4] - x[n-6]) / 32). Here x[i] for i < 0 is taken as zero.
- R3: For the same n, `hi_data` equals floor((x[n] - 9x[n-2] + 16x[n-3] - 9x[n-4] + x[n-6]) / 32), again with zero history.
- R4: `band_valid` pulses once per even-indexed sample, exactly two cycles after the cycle in which that sample was presented. It is never high in two consecutive cycles, and idle cycles do not change sub-band values.
- R5: Let u0 and u1 be the lowpass and highpass sub-bands zero-stuffed to full rate, with pair m placed at index 2m and zeros at odd indices. Let A[j] be the sum over k of h1[k]·u0[j-k] and B[j] the sum of h0[k]·u1[j-k], using the integer taps of R3 and R2. Merged sample j is then floor((B[j] - A[j]) / 16), multiplied by +1 for even j and by -1 for odd j.
- R6: Each sub-band pair gives two merged samples, the even one two cycles and the odd one three cycles after its `band_valid` cycle.
- R7: A constant input K gives `lo_data` = K, `hi_data` = 0 and merged samples equal to K once the delay lines have filled.
- R8: An input alternating +K, -K, starting with +K at index 0, gives `lo_data` = 0 and merged sample j equal to x[j-3] once the delay lines have filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | W | Signed input sample |
| lo_data | output | W+1 | Signed lowpass sub-band sample |
| hi_data | output | W+1 | Signed highpass sub-band sample |
| band_valid | output | 1 | Sub-band pair strobe |
| out_data | output | W+4 | Signed merged sample |
| out_valid | output | 1 | Merged sample strobe |

## Verification
A sub-band pair is due two cycles after its even-indexed input sample is presented. Its two merged samples follow four and five cycles after that same input. The bench records the cycle in which each sample is presented. On every strobe it checks the cycle count against these offsets as well as the value. The checks sample on the falling edge, so each register stage lands exactly one count later. With idle gaps in the input the sub-band offset is unchanged, and the merged pair is still tied to its `band_valid` cycle.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
    // fixed half-band filter geometry
    localparam int TAPS     = 7;
    localparam int CTR      = 3;
    localparam int NEAR_A   = 2;
    localparam int NEAR_B   = 4;
    localparam int FAR_B    = 6;
    localparam int GROW     = 6;   // sum growth bits
    localparam int ANA_SHR  = 5;   // divide by 32
    localparam int SYN_SHR  = 4;   // divide by 16 (interpolation gain 2)

    typedef enum logic {PH_EVEN, PH_ODD} phase_e;
    typedef enum logic {SY_WAIT, SY_ZERO} syn_state_e;
endpackage

// File: rtl/hb_fir.sv
module hb_fir #(
    parameter int IW   = 12,
    parameter bit HIGH = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          en,
    input  logic signed [IW-1:0]          din,
    output logic signed [IW+hbw_pkg::GROW-1:0] acc
);
    import hbw_pkg::*;
    localparam int AW = IW + GROW;

    logic signed [IW-1:0] tap [TAPS];
    logic signed [AW-1:0] mid, inner, nine, outer;

    function automatic logic signed [AW-1:0] ext(input logic signed [IW-1:0] v);
        return {{(AW-IW){v[IW-1]}}, v};
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TAPS; i++) tap[i] <= '0;
        end else if (en) begin
            tap[0] <= din;
            for (int i = 1; i < TAPS; i++) tap[i] <= tap[i-1];
        end
    end

    always_comb begin
        mid   = ext(tap[CTR]) <<< 4;
        inner = ext(tap[NEAR_A]) + ext(tap[NEAR_B]);
        nine  = (inner <<< 3) + inner;
        outer = ext(tap[0]) + ext(tap[FAR_B]);
    end

    generate
        if (HIGH) begin : g_high
            assign acc = mid - nine + outer;
        end else begin : g_low
            assign acc = mid + nine - outer;
        end
    endgenerate
endmodule

// File: rtl/hbw_split.sv
module hbw_split #(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_data,
    output logic signed [W:0]   lo_data,
    output logic signed [W:0]   hi_data,
    output logic                band_valid
);
    import hbw_pkg::*;
    localparam int AW = W + GROW;

    phase_e state, state_nx;
    logic   pend;
    logic signed [AW-1:0] acc_lo, acc_hi;

    hb_fir #(.IW(W), .HIGH(1'b0)) u_lo (
        .clk(clk), .rst(rst), .en(in_valid), .din(in_data), .acc(acc_lo));
    hb_fir #(.IW(W), .HIGH(1'b1)) u_hi (
        .clk(clk), .rst(rst), .en(in_valid), .din(in_data), .acc(acc_hi));

    always_ff @(posedge clk) begin
        if (rst) state <= PH_EVEN;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PH_EVEN: if (in_valid) state_nx = PH_ODD;
            PH_ODD:  if (in_valid) state_nx = PH_EVEN;
            default: state_nx = PH_EVEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend       <= 1'b0;
            band_valid <= 1'b0;
            lo_data    <= '0;
            hi_data    <= '0;
        end else begin
            pend       <= in_valid && (state == PH_EVEN);
            band_valid <= pend;
            if (pend) begin
                lo_data <= acc_lo[AW-1:ANA_SHR];
                hi_data <= acc_hi[AW-1:ANA_SHR];
            end
        end
    end

    // R4
    band_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        band_valid |=> !band_valid);
    // R4
    band_source_chk: assert property (@(posedge clk) disable iff (rst)
        band_valid |-> $past(in_valid, 2));
endmodule

// File: rtl/hbw_merge.sv
module hbw_merge #(
    parameter int BW = 13
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [BW-1:0]   lo_data,
    input  logic signed [BW-1:0]   hi_data,
    input  logic                   band_valid,
    output logic signed [BW+2:0]   out_data,
    output logic                   out_valid
);
    import hbw_pkg::*;
    localparam int AW = BW + GROW;
    localparam int DW = AW + 1;
    localparam int OW = DW - SYN_SHR;

    syn_state_e state, state_nx;
    logic push, stuff, pend, odd;
    logic signed [BW-1:0] u_lo, u_hi;
    logic signed [AW-1:0] acc_a, acc_b;
    logic signed [DW-1:0] diff;
    logic signed [OW-1:0] scaled;

    assign stuff = (state == SY_ZERO);
    assign push  = band_valid || stuff;
    assign u_lo  = stuff ? '0 : lo_data;
    assign u_hi  = stuff ? '0 : hi_data;

    // lowpass band through the highpass design, highpass band through the lowpass design
    hb_fir #(.IW(BW), .HIGH(1'b1)) u_fa (
        .clk(clk), .rst(rst), .en(push), .din(u_lo), .acc(acc_a));
    hb_fir #(.IW(BW), .HIGH(1'b0)) u_fb (
        .clk(clk), .rst(rst), .en(push), .din(u_hi), .acc(acc_b));

    always_ff @(posedge clk) begin
        if (rst) state <= SY_WAIT;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SY_WAIT: if (band_valid) state_nx = SY_ZERO;
            SY_ZERO: state_nx = SY_WAIT;
            default: state_nx = SY_WAIT;
        endcase
    end

    always_comb begin
        diff   = {acc_b[AW-1], acc_b} - {acc_a[AW-1], acc_a};
        scaled = diff[DW-1:SYN_SHR];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            odd       <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            pend      <= push;
            odd       <= stuff;
            out_valid <= pend;
            if (pend) out_data <= odd ? -scaled : scaled;
        end
    end

    // R6
    odd_slot_chk: assert property (@(posedge clk) disable iff (rst)
        $past(band_valid, 3) |-> out_valid);
endmodule

// File: rtl/hbw_bank.sv
module hbw_bank #(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_data,
    output logic signed [W:0]   lo_data,
    output logic signed [W:0]   hi_data,
    output logic                band_valid,
    output logic signed [W+3:0] out_data,
    output logic                out_valid
);
    localparam int BW = W + 1;

    hbw_split #(.W(W)) u_split (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .lo_data(lo_data), .hi_data(hi_data), .band_valid(band_valid));

    hbw_merge #(.BW(BW)) u_merge (
        .clk(clk), .rst(rst), .lo_data(lo_data), .hi_data(hi_data),
        .band_valid(band_valid), .out_data(out_data), .out_valid(out_valid));

    // R6
    even_slot_chk: assert property (@(posedge clk) disable iff (rst)
        $past(band_valid, 2) |-> out_valid);
endmodule

// File: tb/sim_hbw_bank.sv
`timescale 1ns/1ps
module sim_hbw_bank;
    localparam int W = 12;
    localparam int N = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [W-1:0] in_data = '0;
    logic signed [W:0]   lo_data, hi_data;
    logic                band_valid, out_valid;
    logic signed [W+3:0] out_data;

    hbw_bank #(.W(W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .lo_data(lo_data), .hi_data(hi_data), .band_valid(band_valid),
        .out_data(out_data), .out_valid(out_valid));

    always #5 clk = ~clk;

    int xs [N];
    int incyc [N];
    int nx = 0, nb = 0, no = 0;
    int cyc = 0;
    int nchk = 0, nerr = 0;
    int mode = 0;      // 0 generic, 1 constant, 2 alternating
    int kval = 0;
    bit done = 1'b0;
    int h0n [7] = '{-1, 0, 9, 16, 9, 0, -1};
    int h1n [7] = '{1, 0, -9, 16, -9, 0, 1};

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int xv(input int i);
        return (i < 0) ? 0 : xs[i];
    endfunction

    function automatic int band(input int m, input bit high);
        int s = 0;
        for (int k = 0; k < 7; k++) s += (high ? h1n[k] : h0n[k]) * xv(2*m - k);
        return s >>> 5;
    endfunction

    function automatic int stuffed(input int i, input bit high);
        if (i < 0 || (i % 2) != 0) return 0;
        return band(i / 2, high);
    endfunction

    function automatic int merged(input int j);
        int a = 0, b = 0, y;
        for (int k = 0; k < 7; k++) begin
            a += h1n[k] * stuffed(j - k, 1'b0);
            b += h0n[k] * stuffed(j - k, 1'b1);
        end
        y = (b - a) >>> 4;
        return (j % 2 == 0) ? y : -y;
    endfunction

    // monitor on the falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (band_valid) begin
                chk(cyc == incyc[2*nb] + 2, "R4 band timing", cyc, incyc[2*nb] + 2);
                chk(int'(lo_data) == band(nb, 1'b0), "R2 lowpass", int'(lo_data), band(nb, 1'b0));
                chk(int'(hi_data) == band(nb, 1'b1), "R3 highpass", int'(hi_data), band(nb, 1'b1));
                if (mode == 1 && nb >= 4) begin
                    chk(int'(lo_data) == kval, "R7 lowpass constant", int'(lo_data), kval);
                    chk(int'(hi_data) == 0, "R7 highpass constant", int'(hi_data), 0);
                end
                if (mode == 2 && nb >= 4)
                    chk(int'(lo_data) == 0, "R8 lowpass alternating", int'(lo_data), 0);
                nb++;
            end
            if (out_valid) begin
                chk(cyc == incyc[2*(no/2)] + 4 + (no % 2), "R6 merge timing",
                    cyc, incyc[2*(no/2)] + 4 + (no % 2));
                chk(int'(out_data) == merged(no), "R5 merged value", int'(out_data), merged(no));
                if (mode == 1 && no >= 10)
                    chk(int'(out_data) == kval, "R7 merged constant", int'(out_data), kval);
                if (mode == 2 && no >= 10)
                    chk(int'(out_data) == xv(no - 3), "R8 merged alternating", int'(out_data), xv(no - 3));
                no++;
            end
        end
    end

    task automatic feed(input bit v, input int val);
        @(negedge clk);
        in_valid = v;
        in_data  = W'(val);
        if (v) begin
            xs[nx]    = val;
            incyc[nx] = cyc;
            nx++;
        end
    endtask

    task automatic start_phase(input int md, input int k);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R1
        chk(!band_valid && !out_valid, "R1 strobes in reset", {band_valid, out_valid}, 0);
        chk(lo_data == 0 && hi_data == 0 && out_data == 0, "R1 data in reset",
            int'(lo_data) + int'(hi_data) + int'(out_data), 0);
        rst = 1'b0;
        nx = 0; nb = 0; no = 0;
        mode = md; kval = k;
        @(negedge clk);
        chk(!band_valid && !out_valid && out_data == 0, "R1 after release",
            {band_valid, out_valid}, 0);
    endtask

    task automatic drain();
        repeat (10) feed(1'b0, 0);
        chk(nb == (nx + 1) / 2, "R4 band count", nb, (nx + 1) / 2);
        chk(no == 2 * nb, "R6 merged count", no, 2 * nb);
    endtask

    initial begin
        // constant input
        start_phase(1, 700);
        for (int i = 0; i < 40; i++) feed(1'b1, 700);
        drain();
        start_phase(1, -2048);
        for (int i = 0; i < 40; i++) feed(1'b1, -2048);
        drain();
        // alternating input
        start_phase(2, 500);
        for (int i = 0; i < 40; i++) feed(1'b1, (i % 2 == 0) ? 500 : -500);
        drain();
        // impulses of extreme amplitude at each offset of a 14-sample window
        for (int p = 0; p < 14; p++) begin
            start_phase(0, 0);
            for (int i = 0; i < 24; i++) feed(1'b1, (i == p) ? ((p % 2 == 0) ? 2047 : -2048) : 0);
            drain();
        end
        // random full-scale, continuous
        start_phase(0, 0);
        for (int i = 0; i < 500; i++) feed(1'b1, int'($urandom % 4096) - 2048);
        drain();
        // extremes only
        start_phase(0, 0);
        for (int i = 0; i < 300; i++) feed(1'b1, ($urandom % 2 == 0) ? 2047 : -2048);
        drain();
        // random with idle gaps (R4: gaps change nothing but timing)
        start_phase(0, 0);
        for (int i = 0; i < 500; i++) begin
            if ($urandom % 3 == 0) feed(1'b0, 0);
            else feed(1'b1, int'($urandom % 4096) - 2048);
        end
        drain();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end
endmodule